// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block adds two 32-bit unsigned operands and a one-bit carry input. It produces a 32-bit sum and a carry output. Inside, the operand width is cut into carry-skip groups whose sizes are set by a parameter array. The default split is narrow at both ends and wide in the middle: 1, 3, 4, 5, 6, 5, 4, 3, 1 bits from the least significant end.

Each bit forms a propagate term and a generate term. Its carry-out comes from a two-way selector: the bit's propagate term picks between the incoming carry and the generate term. The carry ripples through these selectors from the bottom of a group to its top. When every propagate term in a group is 1, a group-level selector hands the group's carry-in straight to the next group. Every group boundary has this bypass, the lowest one included.

A parameter `REG_IO` chooses the timing. With `REG_IO=1`, the operands and carry-in are registered, and the sum and carry-out are registered one clock later. With `REG_IO=0`, the path is purely combinational. The block has no valid/ready handshake because it never stalls. It accepts a new operand set on every clock and never applies back-pressure. If the parameter sizes do not add up to the operand width, elaboration stops with an error.

Top module: `vbsa_adder`

## Requirements
- R1: For any operands and carry-in, the 33-bit value {cout_o, sum_o} equals a_i + b_i + cin_i.
- R2: A bit position where both operand bits are 1 sends a carry into the next bit even when no carry arrives. A bit position where both are 0 stops any arriving carry. For example, 0x80000000 + 0x80000000 gives sum 0 with carry-out 1, and 0x7FFFFFFF + 0 + 1 gives 0x80000000 with carry-out 0.
- R3: With the default sizes, the groups start at bits 0, 1, 4, 8, 13, 19, 24, 28 and 31. A carry entering any one group is delivered correctly past that group when every operand bit pair inside the group differs.
- R4: When every propagate term of a group is 1, that group's rippled carry equals its carry-in, so the bypass and the ripple agree. For example, 0xFFFFFFFF + 0 + 1 gives sum 0 with carry-out 1.
- R5: The carry input is added at bit 0. For example, 0x55555555 + 0xAAAAAAAA gives 0xFFFFFFFF with carry-out 0 when cin_i is 0, and 0 with carry-out 1 when cin_i is 1.
- R6: With REG_IO=0, sum_o and cout_o follow the inputs combinationally, with no clock edge in between.
- R7: With REG_IO=1, the result of the inputs present at rising edge N appears on sum_o and cout_o after rising edge N+1. A new operand set is accepted at every edge.
- R8: With REG_IO=1, a synchronous active-high rst clears both register stages. sum_o and cout_o read 0 after any edge at which rst is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the optional registers and the checks |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry input added at bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The clocked checks assume that a_i, b_i and cin_i carry known 0/1 values at every rising edge after reset is released, and that rst is applied before the first operand is used. The latency check also assumes that at least two edges without reset have passed. The stimulus drives every input on the falling edge from the first moment of the run and holds reset for several cycles at the start. It never leaves an input undriven. The directed vectors cover the all-propagate cases group by group. The random vectors mix free values with complement-biased pairs, which keep long propagate runs frequent, so the bypass agreement check is triggered often.

// File: rtl/vbsa_pkg.sv
package vbsa_pkg;

  // Per-bit carry terms: propagate selects the incoming carry, generate
  // supplies the carry when propagate is low.
  typedef struct packed {
    logic prop;
    logic gen;
  } vbsa_pg_t;

  localparam int unsigned VBSA_DEF_WIDTH = 32;
  localparam int unsigned VBSA_DEF_GROUPS = 9;

endpackage

// File: rtl/vbsa_bit_cell.sv
module vbsa_bit_cell
  import vbsa_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic p_o,
  output logic c_o
);

  vbsa_pg_t pg;

  always_comb begin
    pg.prop = a_i ^ b_i;
    pg.gen  = a_i & b_i;
  end

  assign p_o = pg.prop;
  assign s_o = pg.prop ^ c_i;
  // Selector carry: pass the carry through when propagating, else the
  // generate term (equal to both operand bits since they agree).
  assign c_o = pg.prop ? c_i : pg.gen;

endmodule

// File: rtl/vbsa_skip_group.sv
module vbsa_skip_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          c_o,
  output logic          gprop_o,
  output logic          rip_o
);

  logic [GW:0]   chain;
  logic [GW-1:0] p_bits;

  assign chain[0] = c_i;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    vbsa_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .s_o (s_o[i]),
      .p_o (p_bits[i]),
      .c_o (chain[i+1])
    );
  end

  assign gprop_o = &p_bits;
  assign rip_o   = chain[GW];
  // Group bypass: a fully propagating group hands its carry-in onward.
  assign c_o     = gprop_o ? c_i : chain[GW];

endmodule

// File: rtl/vbsa_adder_core.sv
module vbsa_adder_core #(
  parameter int WIDTH = 32,
  parameter int NUM_GRP = 9,
  parameter int GRP_SIZE [NUM_GRP] = '{1, 3, 4, 5, 6, 5, 4, 3, 1}
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               c_i,
  output logic [WIDTH-1:0]   s_o,
  output logic               c_o,
  output logic [NUM_GRP-1:0] grp_ci_o,
  output logic [NUM_GRP-1:0] grp_prop_o,
  output logic [NUM_GRP-1:0] grp_rip_o
);

  // Lowest bit index of group k (also the total width when k == NUM_GRP).
  function automatic int lo_of(input int k);
    int acc = 0;
    for (int i = 0; i < k; i++) acc += GRP_SIZE[i];
    return acc;
  endfunction

  localparam int TOTAL = lo_of(NUM_GRP);

  if (TOTAL != WIDTH) begin : g_bad_sizes
    $error("vbsa_adder_core: group sizes add to %0d, operand width is %0d", TOTAL, WIDTH);
  end

  logic [NUM_GRP:0] gc;

  assign gc[0] = c_i;

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    localparam int LO = lo_of(k);
    localparam int SZ = GRP_SIZE[k];

    vbsa_skip_group #(
      .GW (SZ)
    ) u_grp (
      .a_i     (a_i[LO +: SZ]),
      .b_i     (b_i[LO +: SZ]),
      .c_i     (gc[k]),
      .s_o     (s_o[LO +: SZ]),
      .c_o     (gc[k+1]),
      .gprop_o (grp_prop_o[k]),
      .rip_o   (grp_rip_o[k])
    );
  end

  assign grp_ci_o = gc[NUM_GRP-1:0];
  assign c_o      = gc[NUM_GRP];

endmodule

// File: rtl/vbsa_adder.sv
module vbsa_adder #(
  parameter int WIDTH = 32,
  parameter int NUM_GRP = 9,
  parameter int GRP_SIZE [NUM_GRP] = '{1, 3, 4, 5, 6, 5, 4, 3, 1},
  parameter bit REG_IO = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int RW = WIDTH + 1;

  logic [WIDTH-1:0]   core_a, core_b, core_s;
  logic               core_c, core_co;
  logic [NUM_GRP-1:0] grp_ci, grp_prop, grp_rip;

  vbsa_adder_core #(
    .WIDTH    (WIDTH),
    .NUM_GRP  (NUM_GRP),
    .GRP_SIZE (GRP_SIZE)
  ) u_core (
    .a_i        (core_a),
    .b_i        (core_b),
    .c_i        (core_c),
    .s_o        (core_s),
    .c_o        (core_co),
    .grp_ci_o   (grp_ci),
    .grp_prop_o (grp_prop),
    .grp_rip_o  (grp_rip)
  );

  // Edges seen since reset release, saturating at 2 (used by the checks).
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  if (REG_IO) begin : g_reg
    logic [WIDTH-1:0] a_q, b_q, s_q;
    logic             c_q, co_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        a_q  <= '0;
        b_q  <= '0;
        c_q  <= 1'b0;
        s_q  <= '0;
        co_q <= 1'b0;
      end else begin
        a_q  <= a_i;
        b_q  <= b_i;
        c_q  <= cin_i;
        s_q  <= core_s;
        co_q <= core_co;
      end
    end

    assign core_a = a_q;
    assign core_b = b_q;
    assign core_c = c_q;
    assign sum_o  = s_q;
    assign cout_o = co_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (sum_o == '0 && cout_o == 1'b0)); // R8

    AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> ({cout_o, sum_o} ==
        $past({1'b0, a_i} + {1'b0, b_i} + RW'(cin_i), 2))); // R7
  end else begin : g_comb
    assign core_a = a_i;
    assign core_b = b_i;
    assign core_c = cin_i;
    assign sum_o  = core_s;
    assign cout_o = core_co;

    AST_COMB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      {cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + RW'(cin_i))); // R6
  end

  AST_CORE_SUM: assert property (@(posedge clk) disable iff (rst)
    {core_co, core_s} == ({1'b0, core_a} + {1'b0, core_b} + RW'(core_c))); // R1

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_chk
    AST_SKIP_AGREE: assert property (@(posedge clk) disable iff (rst)
      grp_prop[k] |-> (grp_rip[k] == grp_ci[k])); // R4
  end

endmodule

// File: tb/test_vbsa_adder.sv
module test_vbsa_adder;

  localparam int W = 32;
  localparam int NG = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_r, sum_c;
  logic         cout_r, cout_c;

  always #4 clk = ~clk; // 125 MHz

  vbsa_adder #(.REG_IO(1'b1)) i_vbsa_adder (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b), .cin_i (cin),
    .sum_o (sum_r), .cout_o (cout_r)
  );

  vbsa_adder #(.REG_IO(1'b0)) i_vbsa_adder_comb (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b), .cin_i (cin),
    .sum_o (sum_c), .cout_o (cout_c)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int gsz [NG] = '{1, 3, 4, 5, 6, 5, 4, 3, 1};

  logic [W:0] hist0 = '0, hist1 = '0;

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic int grp_lo(input int k);
    int acc = 0;
    for (int i = 0; i < k; i++) acc += gsz[i];
    return acc;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One streaming step: check the registered result from two steps back,
  // drive a new operand set, then check the combinational instance.
  task automatic step(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
    @(negedge clk);
    check("R7", {cout_r, sum_r}, hist1);
    hist1 = hist0;
    hist0 = model(x, y, c);
    a = x; b = y; cin = c;
    #1;
    check(req, {cout_c, sum_c}, hist0);
    check("R6", {cout_c, sum_c}, model(a, b, cin));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    a = 32'hDEAD_BEEF; b = 32'h1234_5678; cin = 1'b1;
    @(negedge clk);
    check("R8", {cout_r, sum_r}, '0);
    a = 32'hFFFF_FFFF; b = 32'h0000_0001;
    @(negedge clk);
    check("R8", {cout_r, sum_r}, '0);
    rst = 1'b0;
    hist1 = '0;
    hist0 = model(a, b, cin);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R4 / R5: full propagate and carry-in cases
    step(32'hFFFF_FFFF, 32'h0, 1'b1, "R4");
    step(32'hFFFF_FFFF, 32'h1, 1'b0, "R4");
    step(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R5");
    step(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5");
    step(32'h0, 32'h0, 1'b1, "R5");
    // R2: generate and kill
    step(32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    step(32'h7FFF_FFFF, 32'h0, 1'b1, "R2");
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1");

    // R3: each group fully propagating, with and without a carry into it
    for (int k = 0; k < NG; k++) begin
      int lo = grp_lo(k);
      logic [W-1:0] mask = ((W'(1) << gsz[k]) - 1) << lo;
      logic [W-1:0] gbit = (lo == 0) ? '0 : (W'(1) << (lo - 1));
      step(mask | gbit, gbit, (lo == 0), "R3");
      step(mask, '0, 1'b0, "R3");
      step(mask ^ 32'h0F0F_0F0F & ~mask, (32'h0F0F_0F0F & ~mask) | gbit, (lo == 0), "R3");
    end

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x = $urandom;
      logic [W-1:0] y;
      logic         c = $urandom % 2;
      case ($urandom % 4)
        0: y = $urandom;
        1: y = ~x ^ (W'(1) << ($urandom % W));
        2: y = ~x;
        default: y = $urandom & 32'h0000_FFFF;
      endcase
      step(x, y, c, "R1");
      if (n == 1500) do_reset();
    end

    step('0, '0, 1'b0, "R1");
    step('0, '0, 1'b0, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1: watchdog expired got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule